// File: doc/BRIEF.md
# Packet Buffer Reader with Check-Word Gap Insertion

This block sits on the symbol-clock side of a packet stream. Words arrive through a write port with a valid strobe and are stored in a circular buffer. Once a whole packet is stored, the reader starts a frame. First it pauses its read pointer for a programmable number of cycles, which leaves room for Reed-Solomon check words that a later stage inserts. Then it sends the packet's words out on consecutive cycles.

A frame-start marker is high for the whole frame opening: every paused cycle plus the cycle that carries the packet's first word. With no gap it is a single-cycle pulse. With a 16-word gap it lasts 17 cycles.

A sequence-start input restarts the sequence on its falling edge. The input is only looked at on cycles where the write strobe is high. The word written in the cycle that completes the edge is tagged. When that word leaves the buffer, a first-packet flag marks it. A write that finds the buffer full is dropped and sets a sticky error bit.

Top module: `pkt_gap_reader`

## Requirements
- R1: While and right after reset, `rd_valid`, `rd_data`, `frame_start`, `first_pkt` and `ovf_err` are all zero and the buffer is empty.
- R2: A frame starts only when the buffer holds at least `PKT` words. Its first cycle is seen one clock edge after the edge that stores the `PKT`-th word.
- R3: A frame opens with G gap cycles, where G is the gap setting (clamped as in R6). During these cycles `rd_valid` is 0, `rd_data` is 0 and the read pointer does not move.
- R4: `frame_start` is high on exactly G+1 consecutive cycles per frame: the G gap cycles and then the first-word cycle. It is low on every other cycle.
- R5: After the gap, the packet's `PKT` words appear on consecutive cycles with `rd_valid` high, in the order they were written.
- R6: A `gap_len` value above 16 behaves exactly like 16. The value is taken when a frame starts.
- R7: If more than `PKT` words are buffered while the last word of a packet is output, the next frame's first gap cycle (or its first word, when G=0) follows on the very next cycle.
- R8: A sequence reset needs two samples of `seq_start` taken on cycles with `wr_valid` high: one sample high, and a later one low. The word written on the cycle of that low sample is tagged. A high level that is never sampled with `wr_valid` high causes no reset.
- R9: `first_pkt` is high on exactly the cycle that outputs a tagged word, together with `rd_valid`, and is low otherwise.
- R10: A write made while the buffer holds `DEPTH` words is discarded and never appears at the output. `ovf_err` then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock shared by both buffer ports |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | DW | Word to store |
| wr_valid | input | 1 | Write strobe; also qualifies sampling of `seq_start` |
| seq_start | input | 1 | Sequence-start level; its qualified falling edge restarts the sequence |
| gap_len | input | 5 | Number of check-word gap cycles per frame, 0 to 16 |
| rd_data | output | DW | Word read from the buffer, zero when not valid |
| rd_valid | output | 1 | High on cycles carrying a packet word |
| frame_start | output | 1 | High across the gap and the first word of each frame |
| first_pkt | output | 1 | Marks the word written at a sequence reset |
| ovf_err | output | 1 | Sticky flag for a discarded write |

## Verification
All outputs are registered state. A write therefore shows its effect on the buffer fill one edge after it is captured. A frame's first cycle comes one edge later still, and each output word is due on the cycle after the word before it. The bench logs every output one nanosecond after each rising edge. It also records the log index of the edge that captured each write, so the frame-start check looks at exactly the entry after the last write of a packet. The checks for gap length, word order and the flag are then made by walking the log cycle by cycle, counting gap entries and comparing word positions, not by waiting a fixed time.

// File: rtl/pktgap_pkg.sv
package pktgap_pkg;

    localparam int GAP_W   = 5;
    localparam int GAP_MAX = 16;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_GAP  = 2'd1,
        RD_DATA = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic valid;
        logic fstart;
        logic first;
    } rd_flags_t;

    function automatic logic [GAP_W-1:0] gap_clamp(input logic [GAP_W-1:0] len);
        return (len > GAP_W'(GAP_MAX)) ? GAP_W'(GAP_MAX) : len;
    endfunction

endpackage

// File: rtl/pgr_buffer.sv
module pgr_buffer #(
    parameter int DW    = 8,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_tag,
    input  logic          rd_en,
    output logic [DW-1:0] rd_word,
    output logic          rd_tag,
    output logic [CW-1:0] count,
    output logic          ovf
);

    logic [DW-1:0] mem     [DEPTH];
    logic          tag_mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          accept;

    assign accept  = wr_en && (count != CW'(DEPTH));
    assign rd_word = mem[rd_ptr];
    assign rd_tag  = tag_mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr]     <= wr_data;
            tag_mem[wr_ptr] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + AW'(1);
            if (rd_en)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(accept) - CW'(rd_en);
            if (wr_en && !accept) ovf <= 1'b1;
        end
    end

    // R10: fill never exceeds capacity
    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R10: error bit is sticky
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R3: pointer frozen whenever the reader does not consume
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_ptr == $past(rd_ptr));

    // R2: reader never consumes from an empty buffer
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> count != '0);

endmodule

// File: rtl/pgr_seq_edge.sv
module pgr_seq_edge (
    input  logic clk,
    input  logic rst,
    input  logic wr_valid,
    input  logic seq_start,
    output logic seq_evt
);

    logic armed;

    assign seq_evt = wr_valid && !seq_start && armed;

    always_ff @(posedge clk) begin
        if (rst)           armed <= 1'b0;
        else if (wr_valid) armed <= seq_start;
    end

    // R8: an accepted edge disarms until a new high sample
    p_evt_single_r8: assert property (@(posedge clk) disable iff (rst)
        seq_evt |=> !seq_evt);

endmodule

// File: rtl/pgr_read_ctrl.sv
module pgr_read_ctrl
    import pktgap_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PKT   = 188,
    parameter int CW    = 10,
    localparam int WCW  = (PKT > 1) ? $clog2(PKT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    count,
    input  logic [GAP_W-1:0] gap_len,
    input  logic [DW-1:0]    rd_word,
    input  logic             rd_tag,
    output logic             rd_en,
    output logic [DW-1:0]    rd_data,
    output rd_flags_t        flags
);

    rd_state_e        state;
    logic [GAP_W-1:0] gap_cnt;
    logic [WCW-1:0]   word_cnt;
    logic [GAP_W-1:0] entry_gap;
    rd_state_e        entry_state;
    logic             have_pkt;
    logic             have_next;
    logic             last_word;
    logic [5:0]       fs_run;

    assign entry_gap   = gap_clamp(gap_len);
    assign entry_state = (entry_gap == '0) ? RD_DATA : RD_GAP;
    assign have_pkt    = count >= CW'(PKT);
    assign have_next   = count > CW'(PKT);
    assign last_word   = word_cnt == WCW'(PKT - 1);

    assign rd_en        = (state == RD_DATA);
    assign flags.valid  = (state == RD_DATA);
    assign flags.fstart = (state == RD_GAP) || ((state == RD_DATA) && (word_cnt == '0));
    assign flags.first  = (state == RD_DATA) && rd_tag;
    assign rd_data      = (state == RD_DATA) ? rd_word : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RD_IDLE;
            gap_cnt  <= '0;
            word_cnt <= '0;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (have_pkt) begin
                        state    <= entry_state;
                        gap_cnt  <= entry_gap - GAP_W'(1);
                        word_cnt <= '0;
                    end
                end
                RD_GAP: begin
                    if (gap_cnt == '0) state <= RD_DATA;
                    else               gap_cnt <= gap_cnt - GAP_W'(1);
                end
                RD_DATA: begin
                    if (last_word) begin
                        word_cnt <= '0;
                        if (have_next) begin
                            state   <= entry_state;
                            gap_cnt <= entry_gap - GAP_W'(1);
                        end else begin
                            state <= RD_IDLE;
                        end
                    end else begin
                        word_cnt <= word_cnt + WCW'(1);
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               fs_run <= '0;
        else if (flags.fstart) fs_run <= fs_run + 6'd1;
        else                   fs_run <= '0;
    end

    // R4: frame-start run never longer than the largest gap plus one
    p_fs_run_r4: assert property (@(posedge clk) disable iff (rst)
        fs_run <= 6'(GAP_MAX + 1));

    // R4: every packet's first valid word carries the frame marker
    p_rose_valid_fs_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.valid) |-> flags.fstart);

endmodule

// File: rtl/pkt_gap_reader.sv
module pkt_gap_reader
    import pktgap_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PKT   = 188,
    parameter int DEPTH = 512,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_valid,
    input  logic             seq_start,
    input  logic [GAP_W-1:0] gap_len,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             frame_start,
    output logic             first_pkt,
    output logic             ovf_err
);

    logic          seq_evt;
    logic          rd_en;
    logic [DW-1:0] rd_word;
    logic          rd_tag;
    logic [CW-1:0] count;
    rd_flags_t     flags;

    pgr_seq_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .seq_start (seq_start),
        .seq_evt   (seq_evt)
    );

    pgr_buffer #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_valid),
        .wr_data (wr_data),
        .wr_tag  (seq_evt),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .rd_tag  (rd_tag),
        .count   (count),
        .ovf     (ovf_err)
    );

    pgr_read_ctrl #(.DW(DW), .PKT(PKT), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .count   (count),
        .gap_len (gap_len),
        .rd_word (rd_word),
        .rd_tag  (rd_tag),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .flags   (flags)
    );

    assign rd_valid    = flags.valid;
    assign frame_start = flags.fstart;
    assign first_pkt   = flags.first;

    // R9: tagged words are never adjacent at the output
    p_first_isolated_r9: assert property (@(posedge clk) disable iff (rst)
        first_pkt |=> !first_pkt);

    // R9: flag only accompanies a valid word
    p_first_valid_r9: assert property (@(posedge clk) disable iff (rst)
        first_pkt |-> rd_valid);

endmodule

// File: tb/tb_pkt_gap_reader.sv
`timescale 1ns/1ps
module tb_pkt_gap_reader;

    localparam int DW    = 8;
    localparam int PKT   = 8;
    localparam int DEPTH = 16;
    localparam int LOGN  = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          wr_valid = 1'b0;
    logic          seq_start = 1'b0;
    logic [4:0]    gap_len = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          frame_start;
    logic          first_pkt;
    logic          ovf_err;

    int checks = 0;
    int fails  = 0;
    int last_wr = 0;

    logic          lv  [LOGN];
    logic          lfs [LOGN];
    logic          lfp [LOGN];
    logic [DW-1:0] ld  [LOGN];
    int            log_n = 0;

    always #2.5 clk = ~clk;

    pkt_gap_reader #(.DW(DW), .PKT(PKT), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_valid(wr_valid),
        .seq_start(seq_start), .gap_len(gap_len), .rd_data(rd_data),
        .rd_valid(rd_valid), .frame_start(frame_start),
        .first_pkt(first_pkt), .ovf_err(ovf_err)
    );

    always @(posedge clk) begin
        #1;
        if (log_n < LOGN) begin
            lv[log_n]  = rd_valid;
            lfs[log_n] = frame_start;
            lfp[log_n] = first_pkt;
            ld[log_n]  = rd_data;
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int d, input bit s);
        wr_valid  = 1'b1;
        wr_data   = DW'(d);
        seq_start = s;
        @(posedge clk);
        last_wr = log_n;
        @(negedge clk);
    endtask

    task automatic wr_stop();
        wr_valid = 1'b0;
    endtask

    // Walk one frame in the log: gap cycles, first word, remaining words.
    task automatic scan_frame(inout int idx, input int gap, input int base,
                              input bit exp_first, input string greq);
        int  g = 0;
        bit  gz = 1'b1;
        bit  ok = 1'b1;
        int  stray = 0;
        while (idx < log_n && !lfs[idx]) begin
            if (lv[idx]) stray++;
            idx++;
        end
        check(stray == 0, "R5", "valid words outside a frame", stray, 0);
        while (idx < log_n && lfs[idx] && !lv[idx]) begin
            if (ld[idx] != '0) gz = 1'b0;
            g++;
            idx++;
        end
        check(g == gap, greq, "gap cycles with frame_start", g, gap);
        check(gz, "R3", "rd_data zero during gap", int'(gz), 1);
        check(idx < log_n && lv[idx] && lfs[idx] && ld[idx] == DW'(base),
              "R4", "first word with frame_start", int'(ld[idx]), base);
        check(lfp[idx] == exp_first, "R9", "first_pkt on head word",
              int'(lfp[idx]), int'(exp_first));
        idx++;
        for (int k = 1; k < PKT; k++) begin
            if (!(lv[idx] && !lfs[idx] && !lfp[idx] && ld[idx] == DW'(base + k))) ok = 1'b0;
            idx++;
        end
        check(ok, "R5", "remaining words consecutive and in order", int'(ok), 1);
    endtask

    task automatic no_more_valid(input int idx, input string req);
        int n = 0;
        for (int i = idx; i < log_n; i++) if (lv[i] || lfs[i] || lfp[i]) n++;
        check(n == 0, req, "activity after last frame", n, 0);
    endtask

    task automatic t_reset();
        check(!rd_valid && rd_data == '0 && !frame_start && !first_pkt && !ovf_err,
              "R1", "outputs after reset",
              int'({rd_valid, frame_start, first_pkt, ovf_err}), 0);
    endtask

    task automatic t_single_nogap();
        int idx;
        int base;
        gap_len = 5'd0;
        base = log_n;
        for (int i = 0; i < PKT - 1; i++) wr(16'h10 + i, 1'b0);
        wr_stop();
        repeat (12) @(negedge clk);
        no_more_valid(base, "R2");
        wr(16'h10 + PKT - 1, 1'b0);
        wr_stop();
        repeat (20) @(negedge clk);
        check(!lfs[last_wr] && !lv[last_wr], "R2", "no frame on the storing edge",
              int'(lfs[last_wr]), 0);
        check(lfs[last_wr + 1] && lv[last_wr + 1], "R2", "frame one edge after full packet",
              int'(lfs[last_wr + 1]), 1);
        idx = base;
        scan_frame(idx, 0, 16'h10, 1'b0, "R4");
        no_more_valid(idx, "R4");
    endtask

    task automatic t_gap(input int setting, input int expect_gap, input int base_val,
                         input string req);
        int idx;
        int base;
        gap_len = 5'(setting);
        base = log_n;
        for (int i = 0; i < PKT; i++) wr(base_val + i, 1'b0);
        wr_stop();
        repeat (40) @(negedge clk);
        check(lfs[last_wr + 1] && !lv[last_wr + 1], "R3", "gap opens one edge after full packet",
              int'(lv[last_wr + 1]), 0);
        idx = base;
        scan_frame(idx, expect_gap, base_val, 1'b0, req);
        no_more_valid(idx, req);
    endtask

    task automatic t_back_to_back();
        int idx;
        int base;
        gap_len = 5'd3;
        base = log_n;
        for (int i = 0; i < 2 * PKT; i++) wr(16'h60 + i, 1'b0);
        wr_stop();
        repeat (40) @(negedge clk);
        idx = base;
        scan_frame(idx, 3, 16'h60, 1'b0, "R7");
        check(lfs[idx] && !lv[idx], "R7", "next gap follows last word at once",
              int'(lfs[idx]), 1);
        scan_frame(idx, 3, 16'h60 + PKT, 1'b0, "R7");
        no_more_valid(idx, "R7");
        check(!ovf_err, "R10", "no overflow when space remains", int'(ovf_err), 0);
    endtask

    task automatic t_seq_reset();
        int idx;
        int base;
        gap_len = 5'd2;
        base = log_n;
        for (int i = 0; i < PKT; i++) wr(16'h80 + i, 1'b1);
        for (int i = 0; i < PKT; i++) wr(16'h90 + i, 1'b0);
        wr_stop();
        repeat (40) @(negedge clk);
        idx = base;
        scan_frame(idx, 2, 16'h80, 1'b0, "R8");
        scan_frame(idx, 2, 16'h90, 1'b1, "R8");
        no_more_valid(idx, "R9");
    endtask

    task automatic t_unqualified_edge();
        int idx;
        int base;
        gap_len = 5'd1;
        base = log_n;
        seq_start = 1'b1;
        repeat (3) @(negedge clk);
        seq_start = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < PKT; i++) wr(16'hA0 + i, 1'b0);
        wr_stop();
        repeat (30) @(negedge clk);
        idx = base;
        scan_frame(idx, 1, 16'hA0, 1'b0, "R8");
        no_more_valid(idx, "R8");
    endtask

    task automatic t_overflow();
        int idx;
        int base;
        gap_len = 5'd16;
        base = log_n;
        check(!ovf_err, "R10", "error clear before overflow", int'(ovf_err), 0);
        for (int i = 0; i < DEPTH + 4; i++) wr(16'hC0 + i, 1'b0);
        wr_stop();
        check(ovf_err, "R10", "error set after dropped write", int'(ovf_err), 1);
        repeat (80) @(negedge clk);
        idx = base;
        scan_frame(idx, 16, 16'hC0, 1'b0, "R3");
        scan_frame(idx, 16, 16'hC0 + PKT, 1'b0, "R10");
        no_more_valid(idx, "R10");
        check(ovf_err, "R10", "error stays after drain", int'(ovf_err), 1);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_nogap();
        t_gap(16, 16, 16'h20, "R4");
        t_gap(5, 5, 16'h30, "R3");
        t_gap(31, 16, 16'h40, "R6");
        t_gap(17, 16, 16'h50, "R6");
        t_back_to_back();
        t_seq_reset();
        t_unqualified_edge();
        t_overflow();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule